// File: doc/BRIEF.md
# Dot-Matrix Display Controller Host Register Interface

This block is the parallel host-bus front end of an eight-digit dot-matrix display controller. A host drives an active-low chip enable, active-low write and read strobes, a space-select line, five address lines and an 8-bit data bus. The block decodes these into five storage elements:

- a control word;
- a per-digit character memory;
- a per-digit mark (flash-enable) memory;
- a glyph pointer register;
- a user-glyph memory of sixteen 7-row by 5-column bitmaps.

Write strobes pass through a two-stage synchroniser into the system clock domain, and a write takes effect when the synchronised strobe ends. Read data is decoded combinationally from the live bus and storage. The data bus is a plain strobe interface with no back-pressure.

Scanning logic elsewhere in the controller reads the stored state through side ports:

- the control word and the eight mark bits;
- a character lookup by digit;
- a glyph row lookup by glyph index and row.

Writing the control word with its clear bit set starts an eight-cycle sweep that erases the character and mark memories. Host writes are ignored while the sweep runs.

Top module: `dm_hostif`

## Requirements
- R1: After reset (rst_n low), every stored value is zero, clr_busy is 0, dout_oe is 0 and dout is 0.
- R2: A write with space_sel=0 addresses the mark memory. addr[4:3] is ignored, addr[2:0] selects the digit (digit 0 is the leftmost) and din[0] becomes that digit's mark bit. A read returns {7'b0, bit}, and mark_bits[i] shows digit i.
- R3: A write with space_sel=1 and addr[4:3]=2'b11 stores a character entry for digit addr[2:0]. If din[7]=0 the entry is {1'b0, din[6:0]}. If din[7]=1 the entry is {1'b1, 3'b000, din[3:0]}. The entry reads back unchanged and appears on scan_char when scan_digit selects that digit.
- R4: A write with space_sel=1 and addr[4:3]=2'b10 stores all 8 bits into the control word. It reads back and appears on ctrl_word. Bit 7 is the clear command; bits 6..0 are held for other logic.
- R5: A write with space_sel=1 and addr[4:3]=2'b00 stores din[3:0] into the glyph pointer and ignores din[7:4]. A read returns {4'b0, pointer}.
- R6: A write with space_sel=1 and addr[4:3]=2'b01 stores din[4:0] as row addr[2:0] of the glyph selected by the glyph pointer. A read returns {3'b0, columns}. Row 7 does not exist: a write to it is ignored and a read from it returns 0. The same data is visible on scan_glyph_cols.
- R7: A control-word write with bit 7 set raises clr_busy on the commit edge and keeps it high for exactly 8 clocks. When clr_busy falls, all character entries and mark bits are zero, glyph rows are unchanged and ctrl_word bit 7 has returned to 0 with bits 6..0 kept.
- R8: A host write whose commit edge falls while clr_busy is high changes no storage.
- R9: dout_oe is 1 only while rst_n=1, ce_n=0 and rd_n=0. Whenever dout_oe is 0, dout is 0.
- R10: A write commits on the third rising clock edge after ce_n/wr_n are released. No stored value changes while the write strobe is still held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; must be high for host access |
| ce_n | input | 1 | Active-low chip enable |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| space_sel | input | 1 | 0 selects the mark memory, 1 selects the register spaces decoded by addr[4:3] |
| addr | input | 5 | Host address |
| din | input | 8 | Host write data |
| dout | output | 8 | Host read data, zero when not driven |
| dout_oe | output | 1 | Read data valid / bus drive enable |
| ctrl_word | output | 8 | Stored control word |
| mark_bits | output | 8 | Per-digit mark bits, bit i for digit i |
| clr_busy | output | 1 | Clear sweep in progress |
| scan_digit | input | 3 | Digit for the character lookup |
| scan_char | output | 8 | Character entry of scan_digit |
| scan_glyph_idx | input | 4 | Glyph for the row lookup |
| scan_glyph_row | input | 3 | Row for the row lookup |
| scan_glyph_cols | output | 5 | Column bits of the looked-up row |

## Verification
The bench builds the block with its default parameters: 8 digits, 16 glyphs, 7 rows and 5 columns. With these values the nonexistent eighth glyph row is reachable through a 3-bit row address, and every glyph index fits the 4-bit pointer field. The 8-digit sweep is short enough that a write can be landed on its last busy cycle. Random writes and reads across all five spaces are compared with a bench model, and directed cases cover clear timing, writes during a clear, row 7 and strobe-hold timing.

// File: rtl/dmh_pkg.sv
package dmh_pkg;

  typedef enum logic [2:0] {
    SP_MARK  = 3'd0,
    SP_CHAR  = 3'd1,
    SP_CTRL  = 3'd2,
    SP_GPTR  = 3'd3,
    SP_GLYPH = 3'd4
  } space_e;

  typedef struct packed {
    logic       sel;
    logic [4:0] addr;
    logic [7:0] data;
  } bus_req_t;

  function automatic space_e decode_space(input logic sel, input logic [1:0] hi);
    if (!sel) return SP_MARK;
    case (hi)
      2'b11:   return SP_CHAR;
      2'b10:   return SP_CTRL;
      2'b00:   return SP_GPTR;
      default: return SP_GLYPH;
    endcase
  endfunction

endpackage

// File: rtl/dmh_wr_sync.sv
module dmh_wr_sync
  import dmh_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ce_n,
  input  logic     wr_n,
  input  bus_req_t bus_in,
  output logic     commit,
  output bus_req_t req
);
  logic     act_s1, act_s2, act_s2_d;
  bus_req_t req_s1, req_s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_s1   <= 1'b0;
      act_s2   <= 1'b0;
      act_s2_d <= 1'b0;
      req_s1   <= '0;
      req_s2   <= '0;
      req      <= '0;
    end else begin
      act_s1   <= ~ce_n & ~wr_n;
      act_s2   <= act_s1;
      act_s2_d <= act_s2;
      req_s1   <= bus_in;
      req_s2   <= req_s1;
      if (act_s2) req <= req_s2;
    end
  end

  assign commit = act_s2_d & ~act_s2;

  assert_commit_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);

endmodule

// File: rtl/dmh_regs.sv
module dmh_regs
  import dmh_pkg::*;
#(
  parameter int DIGITS = 8,
  parameter int GP_W   = 4,
  localparam int DIG_W = $clog2(DIGITS)
)(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   commit,
  input  bus_req_t               req,
  output logic [7:0]             ctrl_q,
  output logic [DIGITS-1:0]      mark_q,
  output logic [DIGITS-1:0][7:0] char_q,
  output logic [GP_W-1:0]        gptr_q,
  output logic                   busy,
  output logic                   glyph_we
);
  localparam logic [DIG_W-1:0] LAST = DIG_W'(DIGITS - 1);

  space_e           sp;
  logic             wr_ok;
  logic [DIG_W-1:0] dig;
  logic [DIG_W-1:0] sweep;
  logic [7:0]       char_in;

  assign sp       = decode_space(req.sel, req.addr[4:3]);
  assign wr_ok    = commit & ~busy;
  assign dig      = req.addr[DIG_W-1:0];
  assign glyph_we = wr_ok & (sp == SP_GLYPH);
  assign char_in  = req.data[7] ? {1'b1, {(7-GP_W){1'b0}}, req.data[GP_W-1:0]}
                                : {1'b0, req.data[6:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mark_q <= '0;
      char_q <= '0;
      gptr_q <= '0;
      busy   <= 1'b0;
      sweep  <= '0;
    end else if (busy) begin
      mark_q[sweep] <= 1'b0;
      char_q[sweep] <= '0;
      sweep         <= sweep + 1'b1;
      if (sweep == LAST) begin
        busy      <= 1'b0;
        ctrl_q[7] <= 1'b0;
      end
    end else if (wr_ok) begin
      case (sp)
        SP_MARK: mark_q[dig] <= req.data[0];
        SP_CHAR: char_q[dig] <= char_in;
        SP_CTRL: begin
          ctrl_q <= req.data;
          if (req.data[7]) begin
            busy  <= 1'b1;
            sweep <= '0;
          end
        end
        SP_GPTR: gptr_q <= req.data[GP_W-1:0];
        default: ;
      endcase
    end
  end

  logic [3:0] busy_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_len <= '0;
    else if (busy) busy_len <= busy_len + 1'b1;
    else           busy_len <= '0;
  end

  assert_clear_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_len < 4'(DIGITS)));
  assert_clear_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (mark_q == '0 && char_q == '0 && !ctrl_q[7]));
  assert_busy_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && commit) |=> $stable(gptr_q));

endmodule

// File: rtl/dmh_glyph_ram.sv
module dmh_glyph_ram #(
  parameter int GLYPHS = 16,
  parameter int ROWS   = 7,
  parameter int COLS   = 5,
  localparam int GP_W  = $clog2(GLYPHS),
  localparam int ROW_W = $clog2(ROWS + 1),
  localparam int ROW_N = 2 ** ROW_W
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [GP_W-1:0]  w_idx,
  input  logic [ROW_W-1:0] w_row,
  input  logic [COLS-1:0]  w_cols,
  input  logic [GP_W-1:0]  h_idx,
  input  logic [ROW_W-1:0] h_row,
  output logic [COLS-1:0]  h_cols,
  input  logic [GP_W-1:0]  s_idx,
  input  logic [ROW_W-1:0] s_row,
  output logic [COLS-1:0]  s_cols
);
  logic [COLS-1:0] mem [GLYPHS][ROW_N];

  for (genvar c = 0; c < GLYPHS; c++) begin : g_glyph
    for (genvar r = 0; r < ROW_N; r++) begin : g_row
      if (r < ROWS) begin : g_live
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) mem[c][r] <= '0;
          else if (we && w_idx == GP_W'(c) && w_row == ROW_W'(r)) mem[c][r] <= w_cols;
        end
      end else begin : g_void
        assign mem[c][r] = '0;
      end
    end
  end

  assign h_cols = mem[h_idx][h_row];
  assign s_cols = mem[s_idx][s_row];

  assert_void_row_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (h_row >= ROW_W'(ROWS)) |-> (h_cols == '0));

endmodule

// File: rtl/dm_hostif.sv
module dm_hostif
  import dmh_pkg::*;
#(
  parameter int DIGITS = 8,
  parameter int GLYPHS = 16,
  parameter int ROWS   = 7,
  parameter int COLS   = 5,
  localparam int DIG_W = $clog2(DIGITS),
  localparam int GP_W  = $clog2(GLYPHS),
  localparam int ROW_W = $clog2(ROWS + 1)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             wr_n,
  input  logic             rd_n,
  input  logic             space_sel,
  input  logic [4:0]       addr,
  input  logic [7:0]       din,
  output logic [7:0]       dout,
  output logic             dout_oe,
  output logic [7:0]       ctrl_word,
  output logic [DIGITS-1:0] mark_bits,
  output logic             clr_busy,
  input  logic [DIG_W-1:0] scan_digit,
  output logic [7:0]       scan_char,
  input  logic [GP_W-1:0]  scan_glyph_idx,
  input  logic [ROW_W-1:0] scan_glyph_row,
  output logic [COLS-1:0]  scan_glyph_cols
);
  bus_req_t               bus_in, req;
  logic                   commit, glyph_we;
  logic [7:0]             ctrl_q;
  logic [DIGITS-1:0]      mark_q;
  logic [DIGITS-1:0][7:0] char_q;
  logic [GP_W-1:0]        gptr_q;
  logic [COLS-1:0]        h_cols;
  space_e                 rd_sp;
  logic [DIG_W-1:0]       rd_dig;

  assign bus_in = '{sel: space_sel, addr: addr, data: din};

  dmh_wr_sync u_sync (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .wr_n(wr_n),
    .bus_in(bus_in), .commit(commit), .req(req)
  );

  dmh_regs #(.DIGITS(DIGITS), .GP_W(GP_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .commit(commit), .req(req),
    .ctrl_q(ctrl_q), .mark_q(mark_q), .char_q(char_q), .gptr_q(gptr_q),
    .busy(clr_busy), .glyph_we(glyph_we)
  );

  dmh_glyph_ram #(.GLYPHS(GLYPHS), .ROWS(ROWS), .COLS(COLS)) u_glyph (
    .clk(clk), .rst_n(rst_n),
    .we(glyph_we), .w_idx(gptr_q), .w_row(req.addr[ROW_W-1:0]),
    .w_cols(req.data[COLS-1:0]),
    .h_idx(gptr_q), .h_row(addr[ROW_W-1:0]), .h_cols(h_cols),
    .s_idx(scan_glyph_idx), .s_row(scan_glyph_row), .s_cols(scan_glyph_cols)
  );

  assign rd_sp   = decode_space(space_sel, addr[4:3]);
  assign rd_dig  = addr[DIG_W-1:0];
  assign dout_oe = rst_n & ~ce_n & ~rd_n;

  always_comb begin
    dout = '0;
    if (dout_oe) begin
      case (rd_sp)
        SP_MARK:  dout = {7'b0, mark_q[rd_dig]};
        SP_CHAR:  dout = char_q[rd_dig];
        SP_CTRL:  dout = ctrl_q;
        SP_GPTR:  dout = {{(8-GP_W){1'b0}}, gptr_q};
        default:  dout = {{(8-COLS){1'b0}}, h_cols};
      endcase
    end
  end

  assign ctrl_word = ctrl_q;
  assign mark_bits = mark_q;
  assign scan_char = char_q[scan_digit];

  assert_idle_bus_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_oe |-> (dout == 8'h00));

endmodule

// File: tb/dm_hostif_bench.sv
module dm_hostif_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, space_sel = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout, ctrl_word, mark_bits, scan_char;
  logic       dout_oe, clr_busy;
  logic [2:0] scan_digit = '0, scan_glyph_row = '0;
  logic [3:0] scan_glyph_idx = '0;
  logic [4:0] scan_glyph_cols;

  int checks = 0, failures = 0;

  logic [7:0] m_ctrl, m_mark;
  logic [7:0] m_char [8];
  logic [3:0] m_gptr;
  logic [4:0] m_glyph [16][8];

  always #5 clk = ~clk;

  dm_hostif u_dm_hostif (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .wr_n(wr_n), .rd_n(rd_n),
    .space_sel(space_sel), .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
    .ctrl_word(ctrl_word), .mark_bits(mark_bits), .clr_busy(clr_busy),
    .scan_digit(scan_digit), .scan_char(scan_char),
    .scan_glyph_idx(scan_glyph_idx), .scan_glyph_row(scan_glyph_row),
    .scan_glyph_cols(scan_glyph_cols)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] char_entry(input logic [7:0] d);
    return d[7] ? {1'b1, 3'b000, d[3:0]} : {1'b0, d[6:0]};
  endfunction

  function automatic logic [7:0] expect_read(input logic s, input logic [4:0] a);
    if (!s) return {7'b0, m_mark[a[2:0]]};
    case (a[4:3])
      2'b11:   return m_char[a[2:0]];
      2'b10:   return m_ctrl;
      2'b00:   return {4'b0, m_gptr};
      default: return {3'b0, m_glyph[m_gptr][a[2:0]]};
    endcase
  endfunction

  task automatic model_write(input logic s, input logic [4:0] a, input logic [7:0] d);
    if (!s) m_mark[a[2:0]] = d[0];
    else case (a[4:3])
      2'b11:   m_char[a[2:0]] = char_entry(d);
      2'b10:   m_ctrl = d;
      2'b00:   m_gptr = d[3:0];
      default: if (a[2:0] != 3'd7) m_glyph[m_gptr][a[2:0]] = d[4:0];
    endcase
  endtask

  task automatic wr_start(input logic s, input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    space_sel = s; addr = a; din = d; ce_n = 1'b0; wr_n = 1'b0;
  endtask

  task automatic wr_release();
    @(negedge clk);
    ce_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic bus_write(input logic s, input logic [4:0] a, input logic [7:0] d);
    wr_start(s, a, d);
    repeat (2) @(negedge clk);
    wr_release();
    repeat (4) @(negedge clk);
  endtask

  task automatic bus_read(input string req, input logic s, input logic [4:0] a);
    @(negedge clk);
    space_sel = s; addr = a; ce_n = 1'b0; rd_n = 1'b0;
    #2;
    check(req, dout_oe, 1'b1);
    check(req, dout, expect_read(s, a));
    ce_n = 1'b1; rd_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250));
    m_ctrl = '0; m_mark = '0; m_gptr = '0;
    for (int i = 0; i < 8; i++) m_char[i] = '0;
    for (int g = 0; g < 16; g++) for (int r = 0; r < 8; r++) m_glyph[g][r] = '0;

    repeat (3) @(negedge clk);
    // R1: reset state, R9: no drive while reset
    ce_n = 1'b0; rd_n = 1'b0; #1;
    check("R9 oe in reset", dout_oe, 1'b0);
    check("R1 dout in reset", dout, 8'h00);
    ce_n = 1'b1; rd_n = 1'b1;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ctrl", ctrl_word, 8'h00);
    check("R1 marks", mark_bits, 8'h00);
    check("R1 busy", clr_busy, 1'b0);
    check("R1 oe", dout_oe, 1'b0);
    bus_read("R1 char0", 1'b1, 5'b11_000);
    bus_read("R1 gptr", 1'b1, 5'b00_000);
    bus_read("R1 glyph", 1'b1, 5'b01_011);

    // R9: strobes apart
    @(negedge clk); ce_n = 1'b0; rd_n = 1'b1; space_sel = 1'b1; addr = 5'b10_000; #1;
    check("R9 rd high", {dout_oe, dout}, 9'h000);
    ce_n = 1'b1; rd_n = 1'b0; #1;
    check("R9 ce high", {dout_oe, dout}, 9'h000);
    rd_n = 1'b1;

    // R10: commit timing through ctrl_word
    wr_start(1'b1, 5'b10_000, 8'h15);
    repeat (5) @(negedge clk);
    check("R10 held strobe", ctrl_word, 8'h00);
    wr_release();
    repeat (2) @(negedge clk);
    check("R10 two edges", ctrl_word, 8'h00);
    @(negedge clk);
    check("R10 third edge", ctrl_word, 8'h15);
    m_ctrl = 8'h15;
    repeat (2) @(negedge clk);

    // R3 directed: both entry forms
    bus_write(1'b1, 5'b11_010, 8'h41); model_write(1'b1, 5'b11_010, 8'h41);
    bus_read("R3 ascii", 1'b1, 5'b11_010);
    bus_write(1'b1, 5'b11_101, 8'hFA); model_write(1'b1, 5'b11_101, 8'hFA);
    bus_read("R3 glyph ref", 1'b1, 5'b11_101);
    scan_digit = 3'd5; #1;
    check("R3 scan", scan_char, 8'h8A);

    // R5: upper bits ignored
    bus_write(1'b1, 5'b00_000, 8'hF9); model_write(1'b1, 5'b00_000, 8'hF9);
    bus_read("R5 gptr", 1'b1, 5'b00_000);

    // R6: row 7 write ignored, read zero
    bus_write(1'b1, 5'b01_110, 8'hFF); model_write(1'b1, 5'b01_110, 8'hFF);
    bus_write(1'b1, 5'b01_111, 8'h1F); model_write(1'b1, 5'b01_111, 8'h1F);
    bus_read("R6 row6", 1'b1, 5'b01_110);
    bus_read("R6 row7 zero", 1'b1, 5'b01_111);
    scan_glyph_idx = 4'd9; scan_glyph_row = 3'd6; #1;
    check("R6 scan row6", scan_glyph_cols, 5'h1F);
    scan_glyph_row = 3'd7; #1;
    check("R6 scan row7", scan_glyph_cols, 5'h00);

    // R2: mark with ignored addr[4:3]
    bus_write(1'b0, 5'b10_111, 8'h01); model_write(1'b0, 5'b10_111, 8'h01);
    check("R2 mark_bits", mark_bits, m_mark);
    bus_read("R2 read alias", 1'b0, 5'b01_111);

    // random mix
    for (int it = 0; it < 400; it++) begin
      logic s; logic [4:0] a; logic [7:0] d;
      s = ($urandom % 5) != 0;
      a = 5'($urandom);
      d = 8'($urandom);
      if (s && a[4:3] == 2'b10) d[7] = 1'b0;
      bus_write(s, a, d); model_write(s, a, d);
      bus_read(!s ? "R2 rand" : a[4:3] == 2'b11 ? "R3 rand" : a[4:3] == 2'b10 ? "R4 rand"
               : a[4:3] == 2'b00 ? "R5 rand" : "R6 rand", s, a);
      if (it % 8 == 0) begin
        check("R2 rand marks", mark_bits, m_mark);
        check("R4 rand ctrl", ctrl_word, m_ctrl);
        scan_digit = 3'($urandom);
        scan_glyph_idx = 4'($urandom);
        scan_glyph_row = 3'($urandom);
        #1;
        check("R3 rand scan", scan_char, m_char[scan_digit]);
        check("R6 rand scan", scan_glyph_cols, m_glyph[scan_glyph_idx][scan_glyph_row]);
      end
    end

    // populate before clear
    for (int i = 0; i < 8; i++) begin
      bus_write(1'b0, 5'(i), 8'h01); model_write(1'b0, 5'(i), 8'h01);
      bus_write(1'b1, {2'b11, 3'(i)}, 8'h30 + 8'(i)); model_write(1'b1, {2'b11, 3'(i)}, 8'h30 + 8'(i));
    end
    bus_write(1'b1, 5'b00_000, 8'h03); model_write(1'b1, 5'b00_000, 8'h03);
    bus_write(1'b1, 5'b01_001, 8'h15); model_write(1'b1, 5'b01_001, 8'h15);

    // R7: clear sweep length
    wr_start(1'b1, 5'b10_000, 8'h9B);
    repeat (2) @(negedge clk);
    wr_release();
    repeat (2) @(negedge clk);
    check("R7 busy before commit", clr_busy, 1'b0);
    @(negedge clk);
    check("R7 busy start", clr_busy, 1'b1);
    // R8: write landing inside the sweep
    wr_start(1'b1, 5'b00_000, 8'h0C);
    repeat (2) @(negedge clk);
    wr_release();
    repeat (2) @(negedge clk);
    check("R7 busy seventh", clr_busy, 1'b1);
    @(negedge clk);
    check("R7 busy eighth", clr_busy, 1'b1);
    @(negedge clk);
    check("R7 busy end", clr_busy, 1'b0);
    m_mark = '0;
    for (int i = 0; i < 8; i++) m_char[i] = '0;
    m_ctrl = 8'h1B;
    check("R7 marks cleared", mark_bits, 8'h00);
    check("R7 ctrl bit7", ctrl_word, 8'h1B);
    bus_read("R8 gptr unchanged", 1'b1, 5'b00_000);
    bus_read("R7 char cleared", 1'b1, 5'b11_100);
    bus_read("R7 glyph kept", 1'b1, 5'b01_001);
    scan_digit = 3'd7; #1;
    check("R7 scan char", scan_char, 8'h00);

    // R1: reset again wipes glyphs
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    scan_glyph_idx = 4'd3; scan_glyph_row = 3'd1; #1;
    check("R1 glyph after reset", scan_glyph_cols, 5'h00);
    check("R1 ctrl after reset", ctrl_word, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule